// File: doc/BRIEF.md
# Peak-Tracking Hysteresis Switch

This block converts a stream of signed, digitized differential samples into a two-level switch output. Its decision point is not fixed. A tracking register follows the signal toward its current extreme and keeps the most extreme value reached. The output changes state only when the signal has moved back from that held extreme by a programmable hysteresis. The tracking direction then reverses.

The block keeps no time base and makes no assumption about the sample rate. A signal of any speed, including one that stops moving, is therefore handled the same way.

The tracking register stands in for a tracking converter. On each accepted sample it moves toward the sample by no more than a parameterised step. Two thresholds set the hysteresis:

- one applies while tracking upward,
- the other applies while tracking downward.

Each threshold is taken into the block only when a new tracking phase begins. The outputs are:

- the switch level,
- a one-cycle pulse on every change of that level,
- a separate one-cycle pulse on each low-to-high change,
- the tracking value itself, so that the held peak can be observed.

Top module: `pkhys_switch`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, `sw_out` is 1 (climbing phase), `trk_val` is 0, and both pulses are 0.
- R2: In the climbing phase, each accepted sample above `trk_val` raises `trk_val` by min(STEP_MAX, sample − `trk_val`). `trk_val` therefore never exceeds the sample and holds the highest value reached. A sample at or below `trk_val` that does not trigger a switch leaves `trk_val` unchanged.
- R3: In the climbing phase, an accepted sample with `trk_val` − sample strictly greater than the active hysteresis sets `sw_out` to 0 on the next cycle. `trk_val` is unchanged by that sample.
- R4: In the falling phase, each accepted sample below `trk_val` lowers `trk_val` by min(STEP_MAX, `trk_val` − sample). `trk_val` never goes below the sample and holds the lowest value reached.
- R5: In the falling phase, an accepted sample with sample − `trk_val` strictly greater than the active hysteresis sets `sw_out` to 1 on the next cycle. `trk_val` is unchanged by that sample.
- R6: `edge_pulse` is 1 for exactly the one cycle in which `sw_out` has just changed. `rise_pulse` is 1 only in such a cycle when `sw_out` has become 1.
- R7: The active hysteresis is captured at three moments:
  - `op_hys` on the first accepted sample after reset, which also uses it for its own decision;
  - `op_hys` on each switch into the climbing phase;
  - `rl_hys` on each switch into the falling phase.

  Changes to either threshold at any other time do not affect switching.
- R8: A cycle with `en` = 0 or `smp_vld` = 0 changes neither `sw_out` nor `trk_val`, and no pulse follows it.
- R9: A constant sample, held for any number of accepted samples once `trk_val` has reached it, leaves `sw_out` and `trk_val` unchanged.
- R10: Comparisons do not wrap at full scale. With samples at −2^(SMP_W−1) and 2^(SMP_W−1)−1 and the hysteresis at its maximum, 2^HYS_W−1, a distance of 2^SMP_W−1 switches, and a distance equal to the hysteresis does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enables sample acceptance |
| smp_vld | input | 1 | Marks `smp` as a new sample |
| smp | input | SMP_W | Signed two's complement sample |
| op_hys | input | HYS_W | Unsigned hysteresis for the climbing phase |
| rl_hys | input | HYS_W | Unsigned hysteresis for the falling phase |
| sw_out | output | 1 | Switch level; 1 while climbing |
| edge_pulse | output | 1 | One-cycle pulse after every level change |
| rise_pulse | output | 1 | One-cycle pulse after every low-to-high change |
| trk_val | output | SMP_W | Signed tracking (held peak) value |

## Verification
The sample that triggers a switch also loads the threshold for the phase it opens. Likewise, the first sample after reset both arms the threshold and takes a switching decision. These two functions can therefore land in the same cycle.

The bench provokes this overlap in three ways:

- it changes `op_hys` in the middle of a phase;
- it sets new thresholds just before a switching sample;
- it runs long random stretches in which thresholds change at arbitrary cycles.

A behavioural model of the tracking and switching rules judges every cycle. Directed checks confirm that a mid-phase threshold change does not move the switch point. They also confirm that the value present at the switch governs the following phase.

// File: rtl/pkhys_pkg.sv
package pkhys_pkg;

   // Tracking phase: climbing follows maxima, falling follows minima.
   typedef enum logic {
      PH_FALL  = 1'b0,
      PH_CLIMB = 1'b1
   } phase_e;

endpackage

// File: rtl/pkhys_decide.sv
// Combinational switching decision: distance of the sample back from the
// held peak against the active hysteresis, computed with guard bits.
module pkhys_decide #(
   parameter int SMP_W = 12,
   parameter int HYS_W = 11
) (
   input  logic             climb,
   input  logic [SMP_W-1:0] trk,
   input  logic [SMP_W-1:0] smp,
   input  logic [HYS_W-1:0] hyst,
   output logic             fire,
   output logic             advance,
   output logic [SMP_W-1:0] gap
);
   localparam int EXT_W = SMP_W + 2;

   logic signed [EXT_W-1:0] trk_x;
   logic signed [EXT_W-1:0] smp_x;
   logic signed [EXT_W-1:0] hys_x;
   logic signed [EXT_W-1:0] back;

   always_comb begin
      trk_x   = {{2{trk[SMP_W-1]}}, trk};
      smp_x   = {{2{smp[SMP_W-1]}}, smp};
      hys_x   = {{(EXT_W-HYS_W){1'b0}}, hyst};
      back    = climb ? (trk_x - smp_x) : (smp_x - trk_x);
      fire    = back > hys_x;
      advance = back < 0;
      // Modular difference is exact whenever advance is set.
      gap     = climb ? (smp - trk) : (trk - smp);
   end

endmodule

// File: rtl/pkhys_thr_latch.sv
// Holds the hysteresis of the current phase; loads it only at phase start.
module pkhys_thr_latch #(
   parameter int HYS_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc,
   input  logic             fire,
   input  logic             to_climb,
   input  logic [HYS_W-1:0] op_hys,
   input  logic [HYS_W-1:0] rl_hys,
   output logic [HYS_W-1:0] hyst_eff
);
   logic             arm_q;
   logic [HYS_W-1:0] hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm_q  <= 1'b1;
         hold_q <= '0;
      end else if (acc) begin
         arm_q <= 1'b0;
         if (fire) begin
            hold_q <= to_climb ? op_hys : rl_hys;
         end else if (arm_q) begin
            hold_q <= op_hys;
         end
      end
   end

   assign hyst_eff = arm_q ? op_hys : hold_q;

   // R7: arming is consumed by the first accepted sample
   p_arm_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> !arm_q);

   // R7: no threshold load away from a phase start
   p_hold_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc || (!fire && !arm_q)) |=> $stable(hold_q));

endmodule

// File: rtl/pkhys_tracker.sv
// Tracking register: slews toward the sample by a bounded step.
module pkhys_tracker #(
   parameter int SMP_W    = 12,
   parameter int STEP_MAX = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             move,
   input  logic             up,
   input  logic [SMP_W-1:0] gap,
   output logic [SMP_W-1:0] trk_q
);
   logic [SMP_W-1:0] delta;
   logic [SMP_W-1:0] nxt;

   generate
      if (STEP_MAX == 0) begin : g_free
         always_comb delta = gap;
      end else begin : g_slew
         localparam logic [SMP_W-1:0] STEP_V = SMP_W'(STEP_MAX);
         always_comb delta = (gap > STEP_V) ? STEP_V : gap;

         // R2 / R4: one sample moves the tracker by at most the step
         p_step_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
            ((int'($signed(trk_q)) - int'($signed($past(trk_q)))) <= STEP_MAX) &&
            ((int'($signed(trk_q)) - int'($signed($past(trk_q)))) >= -STEP_MAX));
      end
   endgenerate

   always_comb nxt = up ? (trk_q + delta) : (trk_q - delta);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trk_q <= '0;
      end else if (move) begin
         trk_q <= nxt;
      end
   end

endmodule

// File: rtl/pkhys_switch.sv
module pkhys_switch
   import pkhys_pkg::*;
#(
   parameter int SMP_W    = 12,
   parameter int HYS_W    = 11,
   parameter int STEP_MAX = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             smp_vld,
   input  logic [SMP_W-1:0] smp,
   input  logic [HYS_W-1:0] op_hys,
   input  logic [HYS_W-1:0] rl_hys,
   output logic             sw_out,
   output logic             edge_pulse,
   output logic             rise_pulse,
   output logic [SMP_W-1:0] trk_val
);
   // Elaboration-time parameter checks
   generate
      if (SMP_W < 4) begin : g_bad_smp
         $error("pkhys_switch: SMP_W must be at least 4");
      end
      if (HYS_W < 1 || HYS_W > SMP_W) begin : g_bad_hys
         $error("pkhys_switch: HYS_W must lie in 1..SMP_W");
      end
      if (STEP_MAX < 0 || STEP_MAX >= (1 << (SMP_W-1))) begin : g_bad_step
         $error("pkhys_switch: STEP_MAX out of range");
      end
   endgenerate

   phase_e           phase_q;
   logic             acc;
   logic             climb;
   logic             fire;
   logic             advance;
   logic [SMP_W-1:0] gap;
   logic [HYS_W-1:0] hyst_eff;
   logic             edge_q;
   logic             rise_q;

   assign acc   = en & smp_vld;
   assign climb = (phase_q == PH_CLIMB);

   pkhys_decide #(.SMP_W(SMP_W), .HYS_W(HYS_W)) u_decide (
      .climb   (climb),
      .trk     (trk_val),
      .smp     (smp),
      .hyst    (hyst_eff),
      .fire    (fire),
      .advance (advance),
      .gap     (gap)
   );

   pkhys_thr_latch #(.HYS_W(HYS_W)) u_thr (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc      (acc),
      .fire     (fire),
      .to_climb (!climb),
      .op_hys   (op_hys),
      .rl_hys   (rl_hys),
      .hyst_eff (hyst_eff)
   );

   pkhys_tracker #(.SMP_W(SMP_W), .STEP_MAX(STEP_MAX)) u_trk (
      .clk   (clk),
      .rst_n (rst_n),
      .move  (acc & advance),
      .up    (climb),
      .gap   (gap),
      .trk_q (trk_val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_CLIMB;
         edge_q  <= 1'b0;
         rise_q  <= 1'b0;
      end else begin
         edge_q <= acc & fire;
         rise_q <= acc & fire & !climb;
         if (acc & fire) begin
            phase_q <= climb ? PH_FALL : PH_CLIMB;
         end
      end
   end

   assign sw_out     = climb;
   assign edge_pulse = edge_q;
   assign rise_pulse = rise_q;

   // R1: reset leaves the switch high with the tracker at zero
   p_reset_state_r1: assert property (@(posedge clk)
      !rst_n |=> (sw_out && (trk_val == '0) && !edge_pulse));

   // R6: an edge pulse always accompanies a level change
   p_edge_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
      edge_pulse |-> (sw_out != $past(sw_out)));

   // R6: rise pulse only on a low-to-high change
   p_rise_sub_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rise_pulse |-> (edge_pulse && sw_out));

   // R8: idle cycles change nothing
   p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(en && smp_vld) |=> ($stable(sw_out) && $stable(trk_val) && !edge_pulse));

   // R2: climbing never carries the tracker past the sample
   p_no_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && advance && climb) |=> ($signed(trk_val) <= $past($signed(smp))));

   // R4: falling never carries the tracker below the sample
   p_no_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && advance && !climb) |=> ($signed(trk_val) >= $past($signed(smp))));

endmodule

// File: tb/test_pkhys_switch.sv
module test_pkhys_switch;
   localparam int SW   = 12;
   localparam int HW   = 11;
   localparam int STEP = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          en = 1'b0;
   logic          vld = 1'b0;
   logic [SW-1:0] smp = '0;
   logic [HW-1:0] op = '0;
   logic [HW-1:0] rl = '0;
   logic          sw_out;
   logic          edge_pulse;
   logic          rise_pulse;
   logic [SW-1:0] trk_val;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   pkhys_switch #(.SMP_W(SW), .HYS_W(HW), .STEP_MAX(STEP)) i_pkhys_switch (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (en),
      .smp_vld    (vld),
      .smp        (smp),
      .op_hys     (op),
      .rl_hys     (rl),
      .sw_out     (sw_out),
      .edge_pulse (edge_pulse),
      .rise_pulse (rise_pulse),
      .trk_val    (trk_val)
   );

   // Behavioural reference model
   int m_trk, m_sw, m_arm, m_hys, m_edge, m_rise, mx, mh;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_trk = 0; m_sw = 1; m_arm = 1; m_hys = 0; m_edge = 0; m_rise = 0;
      end else begin
         m_edge = 0; m_rise = 0;
         if (en && vld) begin
            mx = int'($signed(smp));
            mh = m_arm ? int'(op) : m_hys;
            if (m_arm) m_hys = int'(op);
            m_arm = 0;
            if (m_sw == 1) begin
               if (m_trk - mx > mh) begin
                  m_sw = 0; m_edge = 1; m_hys = int'(rl);
               end else if (mx > m_trk) begin
                  m_trk += (mx - m_trk > STEP) ? STEP : (mx - m_trk);
               end
            end else begin
               if (mx - m_trk > mh) begin
                  m_sw = 1; m_edge = 1; m_rise = 1; m_hys = int'(op);
               end else if (mx < m_trk) begin
                  m_trk -= (m_trk - mx > STEP) ? STEP : (m_trk - mx);
               end
            end
         end
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R2 trk_val vs model", int'($signed(trk_val)), m_trk);
         chk("R3 sw_out vs model", int'(sw_out), m_sw);
         chk("R6 edge_pulse vs model", int'(edge_pulse), m_edge);
         chk("R6 rise_pulse vs model", int'(rise_pulse), m_rise);
      end
   end

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog R8 actual timeout expected completion");
      finish_up();
   end

   task automatic put(input int x, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         smp = SW'(x); vld = 1'b1; en = 1'b1;
      end
      @(negedge clk);
      vld = 1'b0;
   endtask

   task automatic trk_is(input string tag, input int exp);
      chk(tag, int'($signed(trk_val)), exp);
   endtask

   int xw;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: state right after reset release
      chk("R1 sw_out after reset", int'(sw_out), 1);
      trk_is("R1 trk_val after reset", 0);
      chk("R1 edge_pulse after reset", int'(edge_pulse), 0);
      chk("R1 rise_pulse after reset", int'(rise_pulse), 0);

      op = 11'd100; rl = 11'd80;
      put(200, 3);
      trk_is("R2 bounded climb after 3 samples", 96);
      put(200, 7);
      trk_is("R2 climb stops at sample", 200);
      chk("R2 still climbing", int'(sw_out), 1);

      // R8: ignored cycles
      for (int i = 0; i < 5; i++) begin
         @(negedge clk); en = 1'b0; vld = 1'b1; smp = SW'(-1000);
      end
      for (int i = 0; i < 5; i++) begin
         @(negedge clk); en = 1'b1; vld = 1'b0;
      end
      @(negedge clk);
      trk_is("R8 trk_val unchanged while idle", 200);
      chk("R8 sw_out unchanged while idle", int'(sw_out), 1);
      chk("R8 no pulse while idle", int'(edge_pulse), 0);

      // R7: mid-phase change of op_hys is ignored
      op = 11'd10;
      put(150, 1);
      chk("R7 mid-phase threshold ignored", int'(sw_out), 1);
      put(100, 1);
      chk("R3 no switch at exact hysteresis", int'(sw_out), 1);
      put(99, 1);
      chk("R3 switch to low", int'(sw_out), 0);
      chk("R6 edge pulse on fall", int'(edge_pulse), 1);
      chk("R6 no rise pulse on fall", int'(rise_pulse), 0);
      trk_is("R3 tracker held on switch", 200);

      put(99, 10);
      trk_is("R4 falling tracks down to sample", 99);
      put(99, 50);
      trk_is("R9 stationary tracker", 99);
      chk("R9 stationary level", int'(sw_out), 0);

      put(179, 1);
      chk("R5 no switch at exact hysteresis", int'(sw_out), 0);
      trk_is("R4 sample above tracker holds it", 99);
      put(180, 1);
      chk("R5 switch to high", int'(sw_out), 1);
      chk("R6 rise pulse", int'(rise_pulse), 1);
      chk("R6 edge pulse on rise", int'(edge_pulse), 1);
      put(180, 5);
      trk_is("R2 climb after rise", 180);

      rl = 11'd2047; op = 11'd2047;
      put(169, 1);
      chk("R7 threshold captured at switch used", int'(sw_out), 0);

      // R10: full-scale extremes
      put(-2048, 80);
      trk_is("R10 tracker reaches negative full scale", -2048);
      put(-1, 1);
      chk("R10 distance equal to hysteresis no switch", int'(sw_out), 0);
      put(2047, 1);
      chk("R10 full-scale rise switches", int'(sw_out), 1);
      put(2047, 140);
      trk_is("R10 tracker reaches positive full scale", 2047);
      put(0, 1);
      chk("R10 hysteresis boundary no switch", int'(sw_out), 1);
      put(-2048, 1);
      chk("R10 full-scale fall switches", int'(sw_out), 0);

      // Random stretch compared against the model every cycle
      xw = 0;
      for (int i = 0; i < 6000; i++) begin
         @(negedge clk);
         xw += int'($urandom_range(0, 60)) - 30;
         if ($urandom_range(0, 99) < 3) xw = int'($urandom_range(0, 4095)) - 2048;
         if (xw > 2047) xw = 2047;
         if (xw < -2048) xw = -2048;
         smp = SW'(xw);
         vld = ($urandom_range(0, 3) != 0);
         en  = ($urandom_range(0, 9) != 0);
         if ($urandom_range(0, 49) == 0) op = HW'($urandom_range(0, 80));
         if ($urandom_range(0, 49) == 0) rl = HW'($urandom_range(0, 80));
      end
      @(negedge clk); vld = 1'b0;
      @(negedge clk);
      finish_up();
   end

endmodule